// File: doc/BRIEF.md
# Fault Capture Unit

The fault capture unit collects single-cycle fault pulses from a set of sources, such as correctable and uncorrectable memory ECC checkers. Each source also presents a 32-bit address word and a 32-bit information word. A fault is taken only if its source is enabled in a per-source mask and capture is switched on. The unit then latches the first such fault: its source number and both of its words. That record stays frozen until software clears it. Faults that arrive while a record is held do not overwrite it. They only advance a small saturating counter.

A captured fault has one of two effects, chosen by a configuration bit. It either sets an interrupt flag, which is gated by an interrupt mask, or it emits a one-cycle system reset request and sets a reset-cause flag. A separate enable drives a level fault output while a record is held. The record and the reset-cause flag belong to the power-on reset domain, so they survive the warm reset that the request triggers. After reboot, software can read which fault caused the reset. Configuration, the interrupt flag and the request belong to the warm domain.

Top module: `fcap_unit`

## Requirements
- R1: After power-on reset, STATUS (word 3) reads the no-fault value 0x000000FF. DATA0, DATA1, PENDING, IRQ and RCAUSE read 0, and `irq_out`, `fault_out` and `rst_req` are low.
- R2: A pulse on source i is captured only if bit i of SMASK (word 1) is 1 and the capture enable (CFG word 0, bit 0) is 1. Otherwise nothing changes.
- R3: When several qualifying sources pulse in the same cycle, the lowest source number is captured. From the next cycle, STATUS reads {bit31=1, bits[7:0]=source}, DATA0 (word 4) reads that source's address word and DATA1 (word 5) reads its information word.
- R4: While a record is held, further qualifying pulses leave STATUS, DATA0 and DATA1 unchanged. Each cycle with a qualifying pulse adds one to PENDING (word 7), which saturates at 2^PCW-1.
- R5: Any write to STATUS clears the record, DATA0, DATA1 and PENDING. A qualifying pulse in the same cycle as that write is captured as a new record.
- R6: With CFG bit 2 = 0, a capture sets the interrupt flag (IRQ word 6, bit 0). `irq_out` equals that flag ANDed with IMASK (word 2, bit 0). Writing 1 to IRQ bit 0 clears the flag and leaves the record unchanged.
- R7: `fault_out` is high exactly while a record is held and the output enable (CFG bit 1) is 1.
- R8: With CFG bit 2 = 1, a capture drives `rst_req` high for one cycle and sets RCAUSE (word 8, bit 0). It does not set the interrupt flag.
- R9: A warm reset (`rst_n` low) clears CFG, SMASK, IMASK and the interrupt flag. It keeps the record, DATA0, DATA1, PENDING and RCAUSE. Power-on reset clears all of them.
- R10: Writing 1 to RCAUSE bit 0 clears it and leaves the record unchanged.
- R11: CFG, SMASK and IMASK read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, async |
| rst_n | input | 1 | Warm system reset, active low, async |
| flt_pulse | input | NSRC | One-cycle fault pulse per source |
| flt_addr | input | NSRC*32 | Address word per source, source i at [32i+31:32i] |
| flt_info | input | NSRC*32 | Information word per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_out | output | 1 | Masked interrupt |
| fault_out | output | 1 | Fault level output |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench builds the unit with four sources and a 3-bit pending counter. Four sources are enough to exercise lowest-number selection across every mask and pulse combination drawn at random. The short counter lets a few back-to-back fault cycles reach saturation. The two reset inputs are driven separately, so retention across a warm reset and total clearing at power-on can both be observed through the register reads.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
  localparam int unsigned REG_AW = 4;
  localparam logic [7:0] NO_FAULT_ID = 8'hFF;

  typedef enum logic [REG_AW-1:0] {
    A_CFG    = 4'd0,
    A_SMASK  = 4'd1,
    A_IMASK  = 4'd2,
    A_STAT   = 4'd3,
    A_DATA0  = 4'd4,
    A_DATA1  = 4'd5,
    A_IRQ    = 4'd6,
    A_PEND   = 4'd7,
    A_RCAUSE = 4'd8
  } reg_addr_e;

  typedef struct packed {
    logic rst_en;
    logic out_en;
    logic trig_en;
  } cfg_t;
endpackage

// File: rtl/fcap_pick.sv
module fcap_pick #(
  parameter int unsigned NSRC = 4,
  localparam int unsigned IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] req,
  output logic            hit,
  output logic [IDW-1:0]  id
);
  // lower[i] is set when some source below i requests
  logic [NSRC-1:0] lower;
  logic [NSRC-1:0] win;

  assign lower[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < NSRC; g++) begin : g_chain
      assign lower[g] = lower[g-1] | req[g-1];
    end
  endgenerate

  assign win = req & ~lower;
  assign hit = |req;

  always_comb begin
    id = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (win[i]) id = IDW'(i);
    end
  end

  // R3: chosen source requests and nothing lower does
  always_comb begin
    if (hit) begin
      a_r3_lowest: assert (req[id] && ((req & ((NSRC'(1) << id) - NSRC'(1))) == '0))
        else $error("picker chose a non-lowest source");
    end
  end
endmodule

// File: rtl/fcap_cfg.sv
module fcap_cfg #(
  parameter int unsigned NSRC = 4
) (
  input  logic                       clk,
  input  logic                       warm_n,
  input  logic                       reg_wr,
  input  logic [fcap_pkg::REG_AW-1:0] reg_addr,
  input  logic [31:0]                reg_wdata,
  output fcap_pkg::cfg_t             cfg,
  output logic [NSRC-1:0]            smask,
  output logic                       imask,
  output logic                       stat_clr,
  output logic                       irq_clr,
  output logic                       rc_clr
);
  import fcap_pkg::*;

  cfg_t            cfg_q, cfg_d;
  logic [NSRC-1:0] smask_q, smask_d;
  logic            imask_q, imask_d;
  logic            we_cfg, we_smask, we_imask;

  assign we_cfg   = reg_wr && (reg_addr == A_CFG);
  assign we_smask = reg_wr && (reg_addr == A_SMASK);
  assign we_imask = reg_wr && (reg_addr == A_IMASK);
  assign stat_clr = reg_wr && (reg_addr == A_STAT);
  assign irq_clr  = reg_wr && (reg_addr == A_IRQ) && reg_wdata[0];
  assign rc_clr   = reg_wr && (reg_addr == A_RCAUSE) && reg_wdata[0];

  always_comb begin
    cfg_d   = cfg_q;
    smask_d = smask_q;
    imask_d = imask_q;
    if (we_cfg)   cfg_d   = cfg_t'(reg_wdata[2:0]);
    if (we_smask) smask_d = reg_wdata[NSRC-1:0];
    if (we_imask) imask_d = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge warm_n) begin
    if (!warm_n) begin
      cfg_q   <= '0;
      smask_q <= '0;
      imask_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      smask_q <= smask_d;
      imask_q <= imask_d;
    end
  end

  assign cfg   = cfg_q;
  assign smask = smask_q;
  assign imask = imask_q;

  // R11: a register without a write holds its value
  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!warm_n)
    !we_cfg |=> $stable(cfg_q))
    else $error("configuration changed without a write");
endmodule

// File: rtl/fcap_core.sv
module fcap_core #(
  parameter int unsigned NSRC = 4,
  parameter int unsigned DW   = 32,
  parameter int unsigned PCW  = 4,
  localparam int unsigned IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 warm_n,
  input  fcap_pkg::cfg_t       cfg,
  input  logic [NSRC-1:0]      smask,
  input  logic [NSRC-1:0]      pulse,
  input  logic [NSRC*DW-1:0]   addr_bus,
  input  logic [NSRC*DW-1:0]   info_bus,
  input  logic                 stat_clr,
  input  logic                 irq_clr,
  input  logic                 rc_clr,
  output logic                 valid,
  output logic [IDW-1:0]       id,
  output logic [DW-1:0]        data0,
  output logic [DW-1:0]        data1,
  output logic [PCW-1:0]       pend,
  output logic                 irq_flag,
  output logic                 rc_flag,
  output logic                 rst_req
);
  localparam logic [PCW-1:0] PMAX = '1;

  logic [NSRC-1:0] qual;
  logic            hit;
  logic [IDW-1:0]  pick_id;
  logic            open, cap;

  logic           valid_q, valid_d;
  logic [IDW-1:0] id_q, id_d;
  logic [DW-1:0]  d0_q, d0_d, d1_q, d1_d;
  logic [PCW-1:0] pend_q, pend_d;
  logic           rc_q, rc_d;
  logic           irq_q, irq_d;
  logic           req_q, req_d;

  assign qual = pulse & smask & {NSRC{cfg.trig_en}};

  fcap_pick #(.NSRC(NSRC)) u_pick (
    .req (qual),
    .hit (hit),
    .id  (pick_id)
  );

  assign open = !valid_q || stat_clr;
  assign cap  = hit && open;

  // record, retained across warm reset
  always_comb begin
    valid_d = valid_q;
    id_d    = id_q;
    d0_d    = d0_q;
    d1_d    = d1_q;
    pend_d  = pend_q;
    rc_d    = rc_q;
    if (stat_clr) begin
      valid_d = 1'b0;
      id_d    = '0;
      d0_d    = '0;
      d1_d    = '0;
      pend_d  = '0;
    end else if (hit && valid_q && (pend_q != PMAX)) begin
      pend_d = pend_q + PCW'(1);
    end
    if (cap) begin
      valid_d = 1'b1;
      id_d    = pick_id;
      d0_d    = addr_bus[pick_id*DW +: DW];
      d1_d    = info_bus[pick_id*DW +: DW];
    end
    if (rc_clr) rc_d = 1'b0;
    if (cap && cfg.rst_en) rc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      valid_q <= 1'b0;
      id_q    <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
      pend_q  <= '0;
      rc_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      id_q    <= id_d;
      d0_q    <= d0_d;
      d1_q    <= d1_d;
      pend_q  <= pend_d;
      rc_q    <= rc_d;
    end
  end

  // warm-domain notification state
  always_comb begin
    irq_d = irq_q;
    if (irq_clr) irq_d = 1'b0;
    if (cap && !cfg.rst_en) irq_d = 1'b1;
    req_d = cap && cfg.rst_en;
  end

  always_ff @(posedge clk or negedge warm_n) begin
    if (!warm_n) begin
      irq_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      req_q <= req_d;
    end
  end

  assign valid    = valid_q;
  assign id       = id_q;
  assign data0    = d0_q;
  assign data1    = d1_q;
  assign pend     = pend_q;
  assign irq_flag = irq_q;
  assign rc_flag  = rc_q;
  assign rst_req  = req_q;

  // R4: a held record is frozen until cleared
  a_r4_hold: assert property (@(posedge clk) disable iff (!por_n)
    (valid_q && !stat_clr) |=> (valid_q && $stable(id_q) && $stable(d0_q) && $stable(d1_q)))
    else $error("held record changed");

  // R4: pending counter stays saturated
  a_r4_sat: assert property (@(posedge clk) disable iff (!por_n)
    (pend_q == PMAX && !stat_clr) |=> (pend_q == PMAX))
    else $error("pending counter wrapped");

  // R2: a new record needs a qualifying pulse with capture enabled
  a_r2_qualified: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    $rose(valid_q) |-> $past(cfg.trig_en && ((pulse & smask) != '0)))
    else $error("record without qualifying pulse");

  // R8: a reset request always leaves the cause flag set
  a_r8_cause: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    req_q |-> (rc_q && valid_q))
    else $error("reset request without cause flag");

  // R6: interrupt flag only rises together with a record
  a_r6_irq_rec: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    $rose(irq_q) |-> valid_q)
    else $error("interrupt without record");
endmodule

// File: rtl/fcap_unit.sv
module fcap_unit #(
  parameter int unsigned NSRC = 4,
  parameter int unsigned PCW  = 4,
  localparam int unsigned DW  = 32,
  localparam int unsigned IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      flt_pulse,
  input  logic [NSRC*DW-1:0]   flt_addr,
  input  logic [NSRC*DW-1:0]   flt_info,
  input  logic                 reg_wr,
  input  logic [3:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 irq_out,
  output logic                 fault_out,
  output logic                 rst_req
);
  import fcap_pkg::*;

  logic            warm_n;
  cfg_t            cfg;
  logic [NSRC-1:0] smask;
  logic            imask, stat_clr, irq_clr, rc_clr;
  logic            valid, irq_flag, rc_flag;
  logic [IDW-1:0]  id;
  logic [DW-1:0]   data0, data1;
  logic [PCW-1:0]  pend;

  assign warm_n = por_n & rst_n;

  fcap_cfg #(.NSRC(NSRC)) u_cfg (
    .clk       (clk),
    .warm_n    (warm_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cfg       (cfg),
    .smask     (smask),
    .imask     (imask),
    .stat_clr  (stat_clr),
    .irq_clr   (irq_clr),
    .rc_clr    (rc_clr)
  );

  fcap_core #(.NSRC(NSRC), .DW(DW), .PCW(PCW)) u_core (
    .clk      (clk),
    .por_n    (por_n),
    .warm_n   (warm_n),
    .cfg      (cfg),
    .smask    (smask),
    .pulse    (flt_pulse),
    .addr_bus (flt_addr),
    .info_bus (flt_info),
    .stat_clr (stat_clr),
    .irq_clr  (irq_clr),
    .rc_clr   (rc_clr),
    .valid    (valid),
    .id       (id),
    .data0    (data0),
    .data1    (data1),
    .pend     (pend),
    .irq_flag (irq_flag),
    .rc_flag  (rc_flag),
    .rst_req  (rst_req)
  );

  assign irq_out   = irq_flag & imask;
  assign fault_out = valid & cfg.out_en;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG:    reg_rdata[2:0] = cfg;
      A_SMASK:  reg_rdata[NSRC-1:0] = smask;
      A_IMASK:  reg_rdata[0] = imask;
      A_STAT:   reg_rdata = valid ? {1'b1, 23'd0, 8'(id)} : {24'd0, NO_FAULT_ID};
      A_DATA0:  reg_rdata = data0;
      A_DATA1:  reg_rdata = data1;
      A_IRQ:    reg_rdata[0] = irq_flag;
      A_PEND:   reg_rdata[PCW-1:0] = pend;
      A_RCAUSE: reg_rdata[0] = rc_flag;
      default:  reg_rdata = '0;
    endcase
  end

  // R7: fault output never high without a record
  a_r7_fout: assert property (@(posedge clk) disable iff (!warm_n)
    fault_out |-> (reg_addr != A_STAT || reg_rdata[31]))
    else $error("fault output without record");
endmodule

// File: tb/fcap_unit_test.sv
`timescale 1ns/1ps
module fcap_unit_test;
  localparam int NSRC = 4;
  localparam int PCW  = 3;

  logic              clk = 1'b0;
  logic              por_n, rst_n;
  logic [NSRC-1:0]   flt_pulse;
  logic [NSRC*32-1:0] flt_addr, flt_info;
  logic              reg_wr;
  logic [3:0]        reg_addr;
  logic [31:0]       reg_wdata, reg_rdata;
  logic              irq_out, fault_out, rst_req;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  fcap_unit #(.NSRC(NSRC), .PCW(PCW)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .flt_pulse(flt_pulse), .flt_addr(flt_addr), .flt_info(flt_info),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out), .fault_out(fault_out),
    .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic fire(input logic [NSRC-1:0] p);
    flt_pulse = p;
    tick();
    flt_pulse = '0;
  endtask

  function automatic int lowest(input logic [NSRC-1:0] p, input logic [NSRC-1:0] m);
    for (int i = 0; i < NSRC; i++) if (p[i] && m[i]) return i;
    return -1;
  endfunction

  task automatic load_words(input int salt);
    for (int i = 0; i < NSRC; i++) begin
      flt_addr[i*32 +: 32] = $urandom() ^ salt;
      flt_info[i*32 +: 32] = $urandom() + i;
    end
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [NSRC-1:0] m, p;
    int w;
    void'($urandom(32'd17));
    por_n = 0; rst_n = 0; flt_pulse = '0; flt_addr = '0; flt_info = '0;
    reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) tick();
    por_n = 1; rst_n = 1;
    tick();

    // R1 reset state
    rd(4'd3, v); check("R1 status", v, 32'hFF);
    rd(4'd4, v); check("R1 data0", v, 0);
    rd(4'd7, v); check("R1 pend", v, 0);
    rd(4'd8, v); check("R1 rcause", v, 0);
    rd(4'd6, v); check("R1 irq", v, 0);
    check("R1 outputs", {irq_out, fault_out, rst_req}, 0);

    // R11 readback
    wr(4'd0, 32'h3); rd(4'd0, v); check("R11 cfg", v, 3);
    wr(4'd1, 32'h5); rd(4'd1, v); check("R11 smask", v, 5);
    wr(4'd2, 32'h1); rd(4'd2, v); check("R11 imask", v, 1);

    // R2 masked sources ignored
    load_words(1);
    fire(4'hA);
    rd(4'd3, v); check("R2 masked", v, 32'hFF);
    check("R2 no irq", irq_out, 0);
    wr(4'd0, 32'h2);
    fire(4'h5);
    rd(4'd3, v); check("R2 trig off", v, 32'hFF);
    wr(4'd0, 32'h3);

    // R3/R4/R5/R6/R7 random trials
    for (int t = 0; t < 40; t++) begin
      m = NSRC'($urandom_range(1, 15));
      p = NSRC'($urandom_range(0, 15));
      wr(4'd1, 32'(m));
      load_words(t);
      fire(p);
      w = lowest(p, m);
      rd(4'd3, v);
      if (w < 0) begin
        check("R2 random none", v, 32'hFF);
        check("R7 no record", fault_out, 0);
      end else begin
        check("R3 status", v, 32'h8000_0000 | w);
        rd(4'd4, v); check("R3 data0", v, flt_addr[w*32 +: 32]);
        rd(4'd5, v); check("R3 data1", v, flt_info[w*32 +: 32]);
        check("R6 irq_out", irq_out, 1);
        check("R7 fault_out", fault_out, 1);
        load_words(t + 100);
        fire(m);
        rd(4'd3, v); check("R4 held id", v, 32'h8000_0000 | w);
        rd(4'd7, v); check("R4 pend", v, 1);
        wr(4'd6, 32'h1);
        check("R6 irq cleared", irq_out, 0);
        rd(4'd3, v); check("R6 record kept", v, 32'h8000_0000 | w);
        wr(4'd3, 32'h0);
        rd(4'd3, v); check("R5 cleared", v, 32'hFF);
        rd(4'd4, v); check("R5 data0", v, 0);
        rd(4'd7, v); check("R5 pend", v, 0);
      end
    end

    // R4 saturation
    wr(4'd1, 32'hF);
    fire(4'h4);
    for (int k = 0; k < 10; k++) fire(4'h1);
    rd(4'd7, v); check("R4 saturate", v, 7);
    rd(4'd3, v); check("R4 id after burst", v, 32'h8000_0002);

    // R5 clear with same-cycle fault
    load_words(77);
    reg_wr = 1; reg_addr = 4'd3; reg_wdata = 0; flt_pulse = 4'hC;
    tick();
    reg_wr = 0; flt_pulse = '0;
    rd(4'd3, v); check("R5 recapture", v, 32'h8000_0002);
    rd(4'd5, v); check("R5 recapture data1", v, flt_info[2*32 +: 32]);
    rd(4'd7, v); check("R5 recapture pend", v, 0);

    // R7 output enable off
    wr(4'd0, 32'h1);
    check("R7 out disabled", fault_out, 0);
    // R6 imask off
    wr(4'd2, 32'h0);
    check("R6 masked irq_out", irq_out, 0);
    rd(4'd6, v); check("R6 flag set", v, 1);
    wr(4'd6, 32'h1);
    wr(4'd3, 32'h0);

    // R8 reset mode
    wr(4'd2, 32'h1);
    wr(4'd0, 32'h7);
    load_words(55);
    fire(4'hE);
    check("R8 rst_req", rst_req, 1);
    check("R8 no irq", irq_out, 0);
    tick();
    check("R8 one cycle", rst_req, 0);
    rd(4'd8, v); check("R8 rcause", v, 1);
    rd(4'd6, v); check("R8 irq flag", v, 0);

    // R9 warm reset retention
    rst_n = 0; repeat (2) tick(); rst_n = 1; tick();
    rd(4'd3, v); check("R9 status kept", v, 32'h8000_0001);
    rd(4'd4, v); check("R9 data0 kept", v, flt_addr[32 +: 32]);
    rd(4'd8, v); check("R9 rcause kept", v, 1);
    rd(4'd0, v); check("R9 cfg cleared", v, 0);
    rd(4'd1, v); check("R9 smask cleared", v, 0);

    // R10 cause clear
    wr(4'd8, 32'h1);
    rd(4'd8, v); check("R10 rcause cleared", v, 0);
    rd(4'd3, v); check("R10 record kept", v, 32'h8000_0001);

    // R9 power-on clears all
    por_n = 0; repeat (2) tick(); por_n = 1; tick();
    rd(4'd3, v); check("R9 por status", v, 32'hFF);
    rd(4'd4, v); check("R9 por data0", v, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule